// File: doc/BRIEF.md
# Normalization Shift-Count Detector

This block inspects a signed fixed-point word and reports how far it would have to be shifted left so that the first bit that differs from the sign bit ends up directly below the sign position. It accepts either a 40-bit word, whose top 8 bits are guard bits above a 32-bit word, or a plain 32-bit word. A mode input selects between the two. The block only computes the count. Another stage performs the shift.

The count is always measured against the 32-bit binary point. In 40-bit mode, a value whose guard bits carry significance therefore produces a negative count, down to -8. The count is returned as integer data: a small two's-complement number placed in the upper half of the 32-bit word, sign-extended through the guard bits, with the lower 16 bits cleared. In 40-bit mode this gives a 24-bit integer, and in 32-bit mode a 16-bit integer. The result is registered and appears one clock after an input strobe.

Top module: `norm_detect`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. `result` takes the value computed from that strobe at the same edge.
- R2: While `in_valid` is low, `result` keeps its last value whatever `din` and `guard_mode` do.
- R3: With `guard_mode`=0, only `din[31:0]` matters and `din[39:32]` is ignored. The count is the number of consecutive bits from bit 30 downward that equal bit 31, so it lies in 0..31.
- R4: With `guard_mode`=1, the count is the number of consecutive bits from bit 38 downward that equal bit 39, minus 8, so it lies in -8..31.
- R5: A word whose examined bits are all zero or all one gives a count of 31 in either mode.
- R6: The count is a 6-bit two's-complement value in `result[21:16]`. `result[39:22]` repeats bit 21 and `result[15:0]` is zero.
- R7: While `rst_n` is low, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| guard_mode | input | 1 | 1: 40-bit word with guard bits, 0: 32-bit word |
| din | input | 40 | Word to examine |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 40 | Count in integer-data format |

## Verification
The block keeps one result register. A wrong count shows at the ports in the cycle after the strobe that produced it. A result register that moves without a strobe shows in the next idle cycle, because `din` is changed while `in_valid` is low. The bench compares both outputs with a behavioural model on every clock. It covers the boundary counts -8, 0, 30 and 31, the all-zero and all-one words in both modes, and guard bits that must be ignored in 32-bit mode.

// File: rtl/norm_detect.sv
module norm_detect #(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8,
  parameter int CNT_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      guard_mode,
  input  logic [WORD_W+GUARD_W-1:0] din,
  output logic                      out_valid,
  output logic [WORD_W+GUARD_W-1:0] result
);
  localparam int FULL_W = WORD_W + GUARD_W;
  localparam int HALF_W = WORD_W / 2;
  localparam int EXT_W  = FULL_W - HALF_W - CNT_W;

  logic [FULL_W-1:0] ext;
  logic [CNT_W-1:0]  rsb;
  logic [CNT_W-1:0]  cnt;
  logic              done;

  assign ext = guard_mode ? din : {{GUARD_W{din[WORD_W-1]}}, din[WORD_W-1:0]};

  always_comb begin
    rsb  = '0;
    done = 1'b0;
    for (int i = FULL_W - 2; i >= 0; i--) begin
      if (!done) begin
        if (ext[i] == ext[FULL_W-1]) rsb = rsb + 1'b1;
        else done = 1'b1;
      end
    end
  end

  assign cnt = rsb - CNT_W'(GUARD_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= {{EXT_W{cnt[CNT_W-1]}}, cnt, {HALF_W{1'b0}}};
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2
  AST_NOGUARD_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !guard_mode) |=> !result[HALF_W+CNT_W-1]); // R3
  AST_GUARD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    result[HALF_W+CNT_W-1] |-> (result[HALF_W+CNT_W-2:HALF_W+CNT_W-3] == 2'b11)); // R4
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    result[HALF_W-1:0] == '0); // R6
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    result[FULL_W-1:HALF_W+CNT_W] == {EXT_W{result[HALF_W+CNT_W-1]}}); // R6
endmodule

// File: tb/norm_detect_tb.sv
module norm_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        guard_mode = 1'b0;
  logic [39:0] din = '0;
  logic        out_valid;
  logic [39:0] result;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  string       cur_tag = "R2";
  logic        exp_valid = 1'b0;
  logic [39:0] exp_result = '0;
  string       exp_tag = "R7";

  always #5 clk = ~clk;

  norm_detect u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .guard_mode(guard_mode),
    .din(din), .out_valid(out_valid), .result(result)
  );

  function automatic logic [39:0] model(logic [39:0] d, logic g);
    logic [39:0] v;
    int n;
    int c;
    v = g ? d : {{8{d[31]}}, d[31:0]};
    n = 0;
    for (int i = 38; i >= 0; i--) begin
      if (v[i] != v[39]) break;
      n++;
    end
    c = n - 8;
    return {24'(c), 16'h0000};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid  <= 1'b0;
      exp_result <= '0;
      exp_tag    <= "R7";
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_result <= model(din, guard_mode);
        exp_tag    <= cur_tag;
      end else begin
        exp_tag <= "R2";
      end
    end
  end

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && !finished) begin
      check("R1", {39'b0, out_valid}, {39'b0, exp_valid});
      check(exp_tag, result, exp_result);
      check("R6", {24'b0, result[15:0]}, 40'b0);
      check("R6", {22'b0, result[39:22]}, {22'b0, {18{result[21]}}});
    end
  end

  task automatic drive(logic v, logic g, logic [39:0] d, string tag);
    @(negedge clk);
    in_valid   = v;
    guard_mode = g;
    din        = d;
    cur_tag    = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", {39'b0, out_valid}, 40'b0);
    check("R7", result, 40'b0);
    rst_n = 1'b1;
    running = 1'b1;
    drive(1, 1, 40'h00_4000_0000, "R4");
    drive(1, 1, 40'h40_0000_0000, "R4");
    drive(1, 1, 40'hBF_FFFF_FFFF, "R4");
    drive(1, 1, 40'h00_0000_0001, "R4");
    drive(1, 1, 40'hFF_FFFF_FFFE, "R4");
    drive(1, 1, 40'h00_0000_0000, "R5");
    drive(1, 1, 40'hFF_FFFF_FFFF, "R5");
    drive(1, 0, 40'hA5_0000_0000, "R5");
    drive(1, 0, 40'h3C_FFFF_FFFF, "R5");
    drive(1, 0, 40'h00_0000_0001, "R3");
    drive(1, 0, 40'hFF_4000_0000, "R3");
    drive(1, 0, 40'h00_8000_0000, "R3");
    drive(1, 0, 40'h7E_0001_0000, "R3");
    drive(0, 1, 40'h12_3456_789A, "R2");
    drive(0, 0, 40'h00_0000_0003, "R2");
    drive(1, 1, 40'h00_0000_8000, "R4");
    drive(0, 1, 40'h40_0000_0000, "R2");
    drive(0, 0, 40'hFF_FFFF_FFFF, "R2");
    for (int k = 0; k < 400; k++) begin
      logic [39:0] d;
      logic [5:0]  sh;
      sh = 6'($urandom_range(0, 39));
      d  = {$urandom, $urandom} >> sh;
      if ($urandom_range(0, 1) == 1) d = ~d;
      drive(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), d,
            ($urandom_range(0, 1) == 1) ? "R4" : "R3");
      if (!guard_mode) cur_tag = "R3";
      else cur_tag = "R4";
    end
    drive(0, 0, 40'h0, "R2");
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    running = 1'b0;
    check("R7", {39'b0, out_valid}, 40'b0);
    check("R7", result, 40'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule